// File: doc/BRIEF.md
# Dual-Accumulator Memory-Reference Execute Unit

This block is the execute stage for a 16-bit widening of a classic 12-bit minicomputer instruction set. Each issued instruction brings a 4-bit opcode, a one-bit register selector, the memory operand already fetched by earlier stages, the current program counter and the effective address. The unit holds two accumulators and a link bit. One clock edge after issue it presents the register write-back, any memory write with its data, a skip flag and the next program counter.

The low eight opcodes (top opcode bit clear) keep the classic meanings, so a program whose added bits are all zero runs unchanged. The upper opcodes add OR, subtract, exclusive-or, store-without-clear and a jump-to-subroutine that leaves the return address in an accumulator. The register selector picks the accumulator for every data opcode. On increment-and-skip, the selector turns the operation into decrement-and-skip. Effective-address formation and byte transfers are handled elsewhere. The byte opcodes and the last opcode are rejected here as illegal.

Top module: `dacc_exec`

## Requirements
- R1: While reset is asserted and right after it, both accumulators, the link, next_pc_o and every flag output (done_o, reg_we_o, mem_we_o, skip_o, illegal_o) read zero.
- R2: Results appear on the outputs in the cycle after the issue edge. The register selector (0 = accumulator 0, 1 = accumulator 1) chooses the only accumulator that AND, add, deposit, OR, subtract, XOR, store and register-call may read or write; the other accumulator is left unchanged.
- R3: Opcode 0000 writes R & M, opcode 1000 writes R | M and opcode 1010 writes R ^ M to the selected accumulator.
- R4: Opcode 0001 writes R + M modulo 2^16 and inverts the link when the sum carries out of bit 15.
- R5: Opcode 1001 writes R - M modulo 2^16 and leaves the link unchanged.
- R6: Opcode 0011 writes R to memory and clears R. Opcode 1011 writes R to memory and keeps R.
- R7: Opcode 0010 with selector 0 writes M + 1 to memory. With selector 1 it writes M - 1. In both cases skip_o is raised exactly when the written value is zero.
- R8: next_pc_o is pc + 2 when the skip is taken and pc + 1 for every other non-jump, legal opcode.
- R9: Opcode 0100 writes pc + 1 to memory and sets next_pc_o to ea + 1. Opcode 0101 sets next_pc_o to ea. Neither one changes an accumulator or the link, whatever the selector is.
- R10: Opcode 1100 writes pc + 1 into the selected accumulator and sets next_pc_o to ea.
- R11: Opcodes 1101, 1110 and 1111 raise illegal_o, write no register and no memory, keep both accumulators and the link, and set next_pc_o to pc.
- R12: Opcodes 0110 and 0111 write nothing, do not raise illegal_o, and set next_pc_o to pc + 1.
- R13: mem_we_o, reg_we_o and done_o are high for exactly the one cycle after an issue edge, and stay low after any edge without issue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue_i | input | 1 | Execute the presented instruction at this edge |
| opcode_i | input | 4 | Opcode, top bit is the extension bit |
| rsel_i | input | 1 | Accumulator selector / ISZ direction |
| operand_i | input | 16 | Fetched memory operand |
| pc_i | input | 16 | Address of the instruction |
| ea_i | input | 16 | Effective address |
| done_o | output | 1 | Result outputs valid this cycle |
| reg_we_o | output | 1 | Accumulator written |
| reg_sel_o | output | 1 | Which accumulator was written |
| reg_wdata_o | output | 16 | Value written to the accumulator |
| mem_we_o | output | 1 | Memory write strobe |
| mem_wdata_o | output | 16 | Memory write data |
| skip_o | output | 1 | Skip taken |
| illegal_o | output | 1 | Opcode rejected |
| next_pc_o | output | 16 | Next program counter |
| acc0_o | output | 16 | Accumulator 0 |
| acc1_o | output | 16 | Accumulator 1 |
| link_o | output | 1 | Link bit |

## Verification
The bench targets the wrap points. It adds with a carry out of bit 15 and checks that the link inverts; a unit without the link update would keep it stale. It subtracts below zero and checks that the link stays put. It increments 0xFFFF and decrements 1 to zero, where a wrong skip decode would miss the skip or produce the wrong next PC, and it decrements 0, which must wrap without a skip. It issues the jump opcodes with selector 1 and the three illegal opcodes, then checks that no accumulator moves. A decoder that let the selector through, or that treated the reserved opcodes as stores, would corrupt an accumulator or strobe memory.

// File: rtl/dacc_pkg.sv
package dacc_pkg;

    typedef enum logic [3:0] {
        OP_AND = 4'h0,
        OP_TAD = 4'h1,
        OP_ISZ = 4'h2,
        OP_DCA = 4'h3,
        OP_JMS = 4'h4,
        OP_JMP = 4'h5,
        OP_IOT = 4'h6,
        OP_OPR = 4'h7,
        OP_OR  = 4'h8,
        OP_SUB = 4'h9,
        OP_XOR = 4'hA,
        OP_STA = 4'hB,
        OP_JSR = 4'hC,
        OP_LB  = 4'hD,
        OP_SB  = 4'hE,
        OP_RSV = 4'hF
    } op_e;

    typedef enum logic [2:0] {
        FN_AND,
        FN_ADD,
        FN_OR,
        FN_SUB,
        FN_XOR,
        FN_INC,
        FN_DEC,
        FN_PASS
    } alu_fn_e;

    function automatic logic op_is_illegal(input op_e op);
        return (op == OP_LB) || (op == OP_SB) || (op == OP_RSV);
    endfunction

endpackage

// File: rtl/dacc_alu.sv
module dacc_alu
    import dacc_pkg::*;
#(
    parameter int W = 16
) (
    input  alu_fn_e        fn,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [W-1:0]   y,
    output logic           cout
);

    logic [W:0] wide;

    always_comb begin
        wide = '0;
        unique case (fn)
            FN_AND:  wide = {1'b0, a & b};
            FN_ADD:  wide = {1'b0, a} + {1'b0, b};
            FN_OR:   wide = {1'b0, a | b};
            FN_SUB:  wide = {1'b0, a - b};
            FN_XOR:  wide = {1'b0, a ^ b};
            FN_INC:  wide = {1'b0, b + W'(1)};
            FN_DEC:  wide = {1'b0, b - W'(1)};
            default: wide = {1'b0, a};
        endcase
        y    = wide[W-1:0];
        cout = wide[W];
    end

endmodule

// File: rtl/dacc_pcgen.sv
module dacc_pcgen
    import dacc_pkg::*;
#(
    parameter int W = 16
) (
    input  op_e          op,
    input  logic         skip,
    input  logic [W-1:0] pc,
    input  logic [W-1:0] ea,
    output logic [W-1:0] ret_addr,
    output logic [W-1:0] next_pc
);

    always_comb begin
        ret_addr = pc + W'(1);
        if (op_is_illegal(op)) begin
            next_pc = pc;
        end else begin
            unique case (op)
                OP_JMP, OP_JSR: next_pc = ea;
                OP_JMS:         next_pc = ea + W'(1);
                default:        next_pc = pc + (skip ? W'(2) : W'(1));
            endcase
        end
    end

endmodule

// File: rtl/dacc_accs.sv
module dacc_accs #(
    parameter int W    = 16,
    parameter int NACC = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  we,
    input  logic [$clog2(NACC)-1:0] sel,
    input  logic [W-1:0]          wdata,
    input  logic                  link_we,
    input  logic                  link_d,
    output logic [NACC-1:0][W-1:0] acc,
    output logic                  link
);

    logic [NACC-1:0][W-1:0] bank_q;
    logic                   link_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q <= '0;
            link_q <= 1'b0;
        end else begin
            for (int k = 0; k < NACC; k++) begin
                if (we && (int'(sel) == k)) bank_q[k] <= wdata;
            end
            if (link_we) link_q <= link_d;
        end
    end

    assign acc  = bank_q;
    assign link = link_q;

endmodule

// File: rtl/dacc_exec.sv
module dacc_exec
    import dacc_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         issue_i,
    input  logic [3:0]   opcode_i,
    input  logic         rsel_i,
    input  logic [W-1:0] operand_i,
    input  logic [W-1:0] pc_i,
    input  logic [W-1:0] ea_i,
    output logic         done_o,
    output logic         reg_we_o,
    output logic         reg_sel_o,
    output logic [W-1:0] reg_wdata_o,
    output logic         mem_we_o,
    output logic [W-1:0] mem_wdata_o,
    output logic         skip_o,
    output logic         illegal_o,
    output logic [W-1:0] next_pc_o,
    output logic [W-1:0] acc0_o,
    output logic [W-1:0] acc1_o,
    output logic         link_o
);

    localparam int NACC = 2;

    typedef struct packed {
        logic         done;
        logic         reg_we;
        logic         reg_sel;
        logic [W-1:0] reg_wdata;
        logic         mem_we;
        logic [W-1:0] mem_wdata;
        logic         skip;
        logic         illegal;
        logic [W-1:0] next_pc;
    } out_t;

    op_e                    op;
    alu_fn_e                fn;
    logic [W-1:0]           src;
    logic [W-1:0]           alu_y;
    logic                   alu_c;
    logic                   skip_c;
    logic [W-1:0]           ret_addr;
    logic [W-1:0]           pc_next;
    logic                   link_we_d;
    logic                   link_d;
    logic [NACC-1:0][W-1:0] acc;
    logic                   link;
    out_t                   out_d, out_q;

    assign op  = op_e'(opcode_i);
    assign src = acc[rsel_i];

    always_comb begin
        unique case (op)
            OP_AND:  fn = FN_AND;
            OP_TAD:  fn = FN_ADD;
            OP_OR:   fn = FN_OR;
            OP_SUB:  fn = FN_SUB;
            OP_XOR:  fn = FN_XOR;
            OP_ISZ:  fn = rsel_i ? FN_DEC : FN_INC;
            default: fn = FN_PASS;
        endcase
    end

    dacc_alu #(.W(W)) alu_i (
        .fn   (fn),
        .a    (src),
        .b    (operand_i),
        .y    (alu_y),
        .cout (alu_c)
    );

    assign skip_c = (op == OP_ISZ) && (alu_y == '0);

    dacc_pcgen #(.W(W)) pcgen_i (
        .op       (op),
        .skip     (skip_c),
        .pc       (pc_i),
        .ea       (ea_i),
        .ret_addr (ret_addr),
        .next_pc  (pc_next)
    );

    always_comb begin
        out_d     = '0;
        link_we_d = 1'b0;
        link_d    = link ^ alu_c;
        if (issue_i) begin
            out_d.done    = 1'b1;
            out_d.reg_sel = rsel_i;
            out_d.next_pc = pc_next;
            out_d.illegal = op_is_illegal(op);
            unique case (op)
                OP_AND, OP_OR, OP_SUB, OP_XOR: begin
                    out_d.reg_we    = 1'b1;
                    out_d.reg_wdata = alu_y;
                end
                OP_TAD: begin
                    out_d.reg_we    = 1'b1;
                    out_d.reg_wdata = alu_y;
                    link_we_d       = 1'b1;
                end
                OP_ISZ: begin
                    out_d.mem_we    = 1'b1;
                    out_d.mem_wdata = alu_y;
                    out_d.skip      = skip_c;
                end
                OP_DCA: begin
                    out_d.mem_we    = 1'b1;
                    out_d.mem_wdata = src;
                    out_d.reg_we    = 1'b1;
                    out_d.reg_wdata = '0;
                end
                OP_STA: begin
                    out_d.mem_we    = 1'b1;
                    out_d.mem_wdata = src;
                end
                OP_JMS: begin
                    out_d.mem_we    = 1'b1;
                    out_d.mem_wdata = ret_addr;
                end
                OP_JSR: begin
                    out_d.reg_we    = 1'b1;
                    out_d.reg_wdata = ret_addr;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    dacc_accs #(.W(W), .NACC(NACC)) accs_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (out_d.reg_we),
        .sel     (out_d.reg_sel),
        .wdata   (out_d.reg_wdata),
        .link_we (link_we_d),
        .link_d  (link_d),
        .acc     (acc),
        .link    (link)
    );

    assign done_o      = out_q.done;
    assign reg_we_o    = out_q.reg_we;
    assign reg_sel_o   = out_q.reg_sel;
    assign reg_wdata_o = out_q.reg_wdata;
    assign mem_we_o    = out_q.mem_we;
    assign mem_wdata_o = out_q.mem_wdata;
    assign skip_o      = out_q.skip;
    assign illegal_o   = out_q.illegal;
    assign next_pc_o   = out_q.next_pc;
    assign acc0_o      = acc[0];
    assign acc1_o      = acc[1];
    assign link_o      = link;

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !issue_i |=> (!mem_we_o && !reg_we_o && !done_o)); // R13

    AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> (!mem_we_o && !reg_we_o && $stable(acc0_o) && $stable(acc1_o)
                       && $stable(link_o) && next_pc_o == $past(pc_i))); // R11

    AST_SKIP_ONLY_ISZ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        skip_o |-> ($past(opcode_i) == OP_ISZ && mem_wdata_o == '0)); // R7

    AST_SKIP_PC: assert property (@(posedge clk) disable iff (!rst_n)
        skip_o |-> (next_pc_o == $past(pc_i) + W'(2))); // R8

    AST_DCA_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && $past(opcode_i) == OP_DCA)
            |-> (($past(rsel_i) ? acc1_o : acc0_o) == '0)); // R6

    AST_JUMP_KEEPS_ACC: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && ($past(opcode_i) == OP_JMS || $past(opcode_i) == OP_JMP))
            |-> ($stable(acc0_o) && $stable(acc1_o) && $stable(link_o))); // R9

endmodule

// File: tb/dacc_exec_tb_top.sv
module dacc_exec_tb_top;

    localparam int  CLK_PERIOD = 10;
    localparam int  W          = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         issue_i = 1'b0;
    logic [3:0]   opcode_i = '0;
    logic         rsel_i = 1'b0;
    logic [W-1:0] operand_i = '0;
    logic [W-1:0] pc_i = '0;
    logic [W-1:0] ea_i = '0;
    logic         done_o, reg_we_o, reg_sel_o, mem_we_o, skip_o, illegal_o, link_o;
    logic [W-1:0] reg_wdata_o, mem_wdata_o, next_pc_o, acc0_o, acc1_o;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dacc_exec #(.W(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .issue_i(issue_i), .opcode_i(opcode_i),
        .rsel_i(rsel_i), .operand_i(operand_i), .pc_i(pc_i), .ea_i(ea_i),
        .done_o(done_o), .reg_we_o(reg_we_o), .reg_sel_o(reg_sel_o),
        .reg_wdata_o(reg_wdata_o), .mem_we_o(mem_we_o), .mem_wdata_o(mem_wdata_o),
        .skip_o(skip_o), .illegal_o(illegal_o), .next_pc_o(next_pc_o),
        .acc0_o(acc0_o), .acc1_o(acc1_o), .link_o(link_o)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic exec(input logic [3:0] op, input logic r, input logic [W-1:0] m,
                        input logic [W-1:0] pc, input logic [W-1:0] ea);
        @(negedge clk);
        issue_i = 1'b1; opcode_i = op; rsel_i = r;
        operand_i = m; pc_i = pc; ea_i = ea;
        @(negedge clk);
        issue_i = 1'b0;
    endtask

    task automatic check_accs(input string req, input logic [W-1:0] a0,
                              input logic [W-1:0] a1, input logic lk);
        check(req, "acc0", 32'(acc0_o), 32'(a0));
        check(req, "acc1", 32'(acc1_o), 32'(a1));
        check(req, "link", 32'(link_o), 32'(lk));
    endtask

    task automatic t_reset;
        check("R1", "done", 32'(done_o), 0);
        check("R1", "reg_we", 32'(reg_we_o), 0);
        check("R1", "mem_we", 32'(mem_we_o), 0);
        check("R1", "skip", 32'(skip_o), 0);
        check("R1", "illegal", 32'(illegal_o), 0);
        check("R1", "next_pc", 32'(next_pc_o), 0);
        check_accs("R1", 16'h0, 16'h0, 1'b0);
    endtask

    task automatic t_logic;
        exec(4'h1, 1'b0, 16'h00F0, 16'h10, 16'h0);
        check("R2", "done", 32'(done_o), 1);
        check("R4", "tad wdata", 32'(reg_wdata_o), 32'h00F0);
        exec(4'h8, 1'b0, 16'h0F00, 16'h11, 16'h0);
        check("R3", "or", 32'(reg_wdata_o), 32'h0FF0);
        exec(4'hA, 1'b0, 16'h00FF, 16'h12, 16'h0);
        check("R3", "xor", 32'(reg_wdata_o), 32'h0F0F);
        exec(4'h0, 1'b0, 16'hFF00, 16'h13, 16'h0);
        check("R3", "and we", 32'(reg_we_o), 1);
        check("R8", "next_pc", 32'(next_pc_o), 32'h14);
        check_accs("R2", 16'h0F00, 16'h0, 1'b0);
    endtask

    task automatic t_tad_carry;
        exec(4'h1, 1'b1, 16'hFFFF, 16'h20, 16'h0);
        check("R2", "sel", 32'(reg_sel_o), 1);
        check_accs("R4", 16'h0F00, 16'hFFFF, 1'b0);
        exec(4'h1, 1'b1, 16'h0002, 16'h21, 16'h0);
        check_accs("R4", 16'h0F00, 16'h0001, 1'b1);
    endtask

    task automatic t_sub;
        exec(4'h9, 1'b1, 16'h0003, 16'h30, 16'h0);
        check("R5", "sub wdata", 32'(reg_wdata_o), 32'hFFFE);
        check_accs("R5", 16'h0F00, 16'hFFFE, 1'b1);
    endtask

    task automatic t_store;
        exec(4'hB, 1'b1, 16'h1234, 16'h40, 16'h0);
        check("R6", "sta mem_we", 32'(mem_we_o), 1);
        check("R6", "sta data", 32'(mem_wdata_o), 32'hFFFE);
        check("R6", "sta reg_we", 32'(reg_we_o), 0);
        check_accs("R6", 16'h0F00, 16'hFFFE, 1'b1);
        @(negedge clk);
        check("R13", "mem_we idle", 32'(mem_we_o), 0);
        check("R13", "done idle", 32'(done_o), 0);
        exec(4'h3, 1'b1, 16'h0, 16'h41, 16'h0);
        check("R6", "dca r1 data", 32'(mem_wdata_o), 32'hFFFE);
        check_accs("R6", 16'h0F00, 16'h0, 1'b1);
        exec(4'h3, 1'b0, 16'h0, 16'h42, 16'h0);
        check("R6", "dca r0 data", 32'(mem_wdata_o), 32'h0F00);
        check_accs("R6", 16'h0, 16'h0, 1'b1);
    endtask

    task automatic t_isz;
        exec(4'h2, 1'b0, 16'hFFFF, 16'h100, 16'h0);
        check("R7", "inc wrap data", 32'(mem_wdata_o), 0);
        check("R7", "inc wrap skip", 32'(skip_o), 1);
        check("R8", "skip pc", 32'(next_pc_o), 32'h102);
        exec(4'h2, 1'b0, 16'h0005, 16'h110, 16'h0);
        check("R7", "inc data", 32'(mem_wdata_o), 6);
        check("R7", "inc no skip", 32'(skip_o), 0);
        check("R8", "no skip pc", 32'(next_pc_o), 32'h111);
        exec(4'h2, 1'b1, 16'h0001, 16'h120, 16'h0);
        check("R7", "dec zero data", 32'(mem_wdata_o), 0);
        check("R7", "dec zero skip", 32'(skip_o), 1);
        check("R8", "dec skip pc", 32'(next_pc_o), 32'h122);
        exec(4'h2, 1'b1, 16'h0000, 16'h130, 16'h0);
        check("R7", "dec wrap data", 32'(mem_wdata_o), 32'hFFFF);
        check("R7", "dec wrap skip", 32'(skip_o), 0);
        check_accs("R7", 16'h0, 16'h0, 1'b1);
    endtask

    task automatic t_jump;
        exec(4'h1, 1'b1, 16'h0055, 16'h1F0, 16'h0);
        exec(4'h4, 1'b1, 16'hAAAA, 16'h200, 16'h300);
        check("R9", "jms mem_we", 32'(mem_we_o), 1);
        check("R9", "jms data", 32'(mem_wdata_o), 32'h201);
        check("R9", "jms pc", 32'(next_pc_o), 32'h301);
        check("R9", "jms reg_we", 32'(reg_we_o), 0);
        check_accs("R9", 16'h0, 16'h0055, 1'b1);
        exec(4'h5, 1'b1, 16'hAAAA, 16'h210, 16'h040);
        check("R9", "jmp pc", 32'(next_pc_o), 32'h040);
        check("R9", "jmp mem_we", 32'(mem_we_o), 0);
        check_accs("R9", 16'h0, 16'h0055, 1'b1);
    endtask

    task automatic t_jsr;
        exec(4'hC, 1'b0, 16'h0, 16'h0123, 16'h0500);
        check("R10", "jsr reg_we", 32'(reg_we_o), 1);
        check("R10", "jsr pc", 32'(next_pc_o), 32'h0500);
        check_accs("R10", 16'h0124, 16'h0055, 1'b1);
    endtask

    task automatic t_illegal;
        for (int k = 13; k <= 15; k++) begin
            exec(4'(k), 1'b1, 16'h7777, 16'h0600, 16'h0700);
            check("R11", "illegal", 32'(illegal_o), 1);
            check("R11", "reg_we", 32'(reg_we_o), 0);
            check("R11", "mem_we", 32'(mem_we_o), 0);
            check("R11", "pc", 32'(next_pc_o), 32'h0600);
            check_accs("R11", 16'h0124, 16'h0055, 1'b1);
        end
    endtask

    task automatic t_passive;
        for (int k = 6; k <= 7; k++) begin
            exec(4'(k), 1'b0, 16'h1111, 16'h0800, 16'h0900);
            check("R12", "illegal", 32'(illegal_o), 0);
            check("R12", "we", 32'(reg_we_o | mem_we_o), 0);
            check("R12", "pc", 32'(next_pc_o), 32'h0801);
            check_accs("R12", 16'h0124, 16'h0055, 1'b1);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_logic();
        t_tad_carry();
        t_sub();
        t_store();
        t_isz();
        t_jump();
        t_jsr();
        t_illegal();
        t_passive();
        @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule